// File: doc/BRIEF.md
# Halt and Reset-Cause Controller

This block decides when the processor core sleeps and when it wakes. It also records why the most recent reset or wake-up happened. A halt command from the core gates off the system clock and sets a power-down flag. While the core is halted, the block keeps watching four wake sources: an external reset, an interrupt request, a falling edge on a general-purpose port, and the watchdog time-out.

A watchdog time-out has a different effect in each state. While the core runs, the time-out produces a full reset pulse. While the core is halted, it produces only a warm reset pulse, which clears the program counter and the stack pointer and leaves every other register alone. In both states the time-out flag is set. Boot code reads the power-down flag and the time-out flag to tell a cold start from a wake-up or a watchdog recovery.

The block runs on an always-on clock. Every command input is a one-cycle, synchronous request. The port input is asynchronous and passes through a synchroniser inside the block.

Top module: `halt_rc_ctrl`

## Requirements
- R1: After power-up reset, `clk_en` is 1, and `halted`, `pdf`, `tof`, `full_rst`, `warm_rst` and `wdt_clr` are all 0.
- R2: A `halt_cmd` sampled while running sets `halted`, drops `clk_en`, sets `pdf`, clears `tof`, and pulses `wdt_clr` for one cycle. All of these changes show in the cycle after the command edge.
- R3: An `irq` sampled while halted returns to running in the next cycle (`clk_en` = 1) with no reset pulse and with both flags unchanged.
- R4: A `wdt_clr_cmd` sampled while running clears `pdf`, leaves `tof` unchanged, and pulses `wdt_clr` for one cycle.
- R5: A `wdt_ovf` sampled while running pulses `full_rst`, sets `tof`, leaves `pdf` unchanged, and keeps the core running.
- R6: A `wdt_ovf` sampled while halted pulses `warm_rst` (not `full_rst`), sets `tof`, keeps `pdf`, and returns to running.
- R7: An `ext_rst` sampled in either state pulses `full_rst`, clears both flags, and leaves the core running.
- R8: When any bit of `port_in` falls while the core is halted, the core is running again after the third clock edge, counted from the edge at which the low level is first sampled. A falling edge that occurs while running, and any rising edge, never wakes the core.
- R9: While halted, `halt_cmd` and `wdt_clr_cmd` have no effect: `pdf` stays 1, `wdt_clr` stays 0, and the core stays halted.
- R10: When several events are sampled in the same cycle, the priority is `ext_rst` first, then `wdt_ovf`, then `halt_cmd`, then `wdt_clr_cmd`. Only the winning event takes effect.
- R11: `full_rst` and `warm_rst` are never high together. Each stays high for exactly one cycle per triggering cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| halt_cmd | input | 1 | Request from the core to enter the halted state |
| wdt_clr_cmd | input | 1 | Request from the core to clear the watchdog |
| ext_rst | input | 1 | External reset request, synchronous |
| irq | input | 1 | Interrupt request, used as a wake source |
| port_in | input | PORT_W | Port pins; a falling edge on any pin is a wake source |
| wdt_ovf | input | 1 | Watchdog time-out pulse |
| clk_en | output | 1 | System clock enable; 0 gates the core clock |
| halted | output | 1 | High while the core is in the halted state |
| full_rst | output | 1 | One-cycle full chip reset pulse |
| warm_rst | output | 1 | One-cycle reset pulse for the program counter and stack pointer only |
| wdt_clr | output | 1 | One-cycle pulse that clears the watchdog and its prescaler |
| pdf | output | 1 | Power-down flag |
| tof | output | 1 | Time-out flag |

## Verification
Two functions can collide in one cycle: the watchdog time-out and the halt command. The bench asserts `wdt_ovf` and `halt_cmd` together while the core runs. The correct result is a single `full_rst` pulse with `tof` set, `pdf` unchanged, and the core still running with no `wdt_clr` pulse. A second collision asserts `halt_cmd` and `wdt_clr_cmd` together, and the halt must win with `pdf` left at 1.

// File: rtl/halt_rc_pkg.sv
package halt_rc_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } pm_state_e;

  typedef struct packed {
    logic pdf;
    logic tof;
  } cause_t;

  // Next reset-cause value; the arguments are already priority-resolved events.
  function automatic cause_t cause_next(input cause_t cur, input logic ev_ext,
                                        input logic ev_to, input logic ev_halt,
                                        input logic ev_clr);
    cause_t n;
    n = cur;
    if (ev_ext) begin
      n = '0;
    end else if (ev_to) begin
      n.tof = 1'b1;
    end else if (ev_halt) begin
      n.pdf = 1'b1;
      n.tof = 1'b0;
    end else if (ev_clr) begin
      n.pdf = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/halt_rc_wake_sync.sv
module halt_rc_wake_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] pin,
  output logic         fall
);
  logic [W-1:0] fall_bits;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1, s2, s_prev;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          s1     <= 1'b0;
          s2     <= 1'b0;
          s_prev <= 1'b0;
        end else begin
          s1     <= pin[i];
          s2     <= s1;
          s_prev <= s2;
        end
      end
      assign fall_bits[i] = s_prev & ~s2;
    end
  endgenerate

  assign fall = |fall_bits;
endmodule

// File: rtl/halt_rc_fsm.sv
module halt_rc_fsm
  import halt_rc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic halt_cmd,
  input  logic wdt_clr_cmd,
  input  logic ext_rst,
  input  logic irq,
  input  logic port_fall,
  input  logic wdt_ovf,
  output logic halted,
  output logic ev_ext,
  output logic ev_to,
  output logic ev_halt,
  output logic ev_clr,
  output logic full_rst,
  output logic warm_rst,
  output logic wdt_clr
);
  pm_state_e state_q, state_d;
  logic      run;
  logic      ev_full, ev_warm, ev_wake;

  assign run     = (state_q == ST_RUN);
  assign ev_ext  = ext_rst;
  assign ev_to   = wdt_ovf & ~ext_rst;
  assign ev_full = ev_ext | (run & ev_to);
  assign ev_warm = ~run & ev_to;
  assign ev_halt = run & ~ext_rst & ~wdt_ovf & halt_cmd;
  assign ev_clr  = run & ~ext_rst & ~wdt_ovf & ~halt_cmd & wdt_clr_cmd;
  assign ev_wake = ~run & ~ext_rst & ~wdt_ovf & (irq | port_fall);

  always_comb begin
    state_d = state_q;
    if (ev_ext || ev_warm || ev_wake) state_d = ST_RUN;
    else if (ev_halt)                 state_d = ST_HALT;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q  <= ST_RUN;
      full_rst <= 1'b0;
      warm_rst <= 1'b0;
      wdt_clr  <= 1'b0;
    end else begin
      state_q  <= state_d;
      full_rst <= ev_full;
      warm_rst <= ev_warm;
      wdt_clr  <= ev_halt | ev_clr;
    end
  end

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/halt_rc_flags.sv
module halt_rc_flags
  import halt_rc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic ev_ext,
  input  logic ev_to,
  input  logic ev_halt,
  input  logic ev_clr,
  output logic pdf,
  output logic tof
);
  cause_t cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= '0;
    else        cause_q <= cause_next(cause_q, ev_ext, ev_to, ev_halt, ev_clr);
  end

  assign pdf = cause_q.pdf;
  assign tof = cause_q.tof;
endmodule

// File: rtl/halt_rc_ctrl.sv
module halt_rc_ctrl #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              halt_cmd,
  input  logic              wdt_clr_cmd,
  input  logic              ext_rst,
  input  logic              irq,
  input  logic [PORT_W-1:0] port_in,
  input  logic              wdt_ovf,
  output logic              clk_en,
  output logic              halted,
  output logic              full_rst,
  output logic              warm_rst,
  output logic              wdt_clr,
  output logic              pdf,
  output logic              tof
);
  // Internal events, named for the checker
  logic port_fall;
  logic ev_ext, ev_to, ev_halt, ev_clr;

  halt_rc_wake_sync #(.W(PORT_W)) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .pin  (port_in),
    .fall (port_fall)
  );

  halt_rc_fsm u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .halt_cmd   (halt_cmd),
    .wdt_clr_cmd(wdt_clr_cmd),
    .ext_rst    (ext_rst),
    .irq        (irq),
    .port_fall  (port_fall),
    .wdt_ovf    (wdt_ovf),
    .halted     (halted),
    .ev_ext     (ev_ext),
    .ev_to      (ev_to),
    .ev_halt    (ev_halt),
    .ev_clr     (ev_clr),
    .full_rst   (full_rst),
    .warm_rst   (warm_rst),
    .wdt_clr    (wdt_clr)
  );

  halt_rc_flags u_flags (
    .clk    (clk),
    .por_n  (por_n),
    .ev_ext (ev_ext),
    .ev_to  (ev_to),
    .ev_halt(ev_halt),
    .ev_clr (ev_clr),
    .pdf    (pdf),
    .tof    (tof)
  );

  assign clk_en = ~halted;
endmodule

// File: rtl/halt_rc_chk.sv
module halt_rc_chk (
  input logic clk,
  input logic por_n,
  input logic halt_cmd,
  input logic wdt_clr_cmd,
  input logic ext_rst,
  input logic irq,
  input logic wdt_ovf,
  input logic port_fall,
  input logic halted,
  input logic full_rst,
  input logic warm_rst,
  input logic wdt_clr,
  input logic pdf,
  input logic tof
);
  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!halted && halt_cmd && !ext_rst && !wdt_ovf) |=> (halted && pdf && !tof && wdt_clr));

  // R3
  irq_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (halted && irq && !ext_rst && !wdt_ovf) |=> (!halted && !full_rst && !warm_rst));

  // R4
  clear_cmd_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!halted && wdt_clr_cmd && !halt_cmd && !ext_rst && !wdt_ovf) |=> (!pdf && wdt_clr));

  // R5
  run_timeout_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!halted && wdt_ovf && !ext_rst) |=> (full_rst && !warm_rst && tof && !halted));

  // R6
  halt_timeout_chk: assert property (@(posedge clk) disable iff (!por_n)
    (halted && wdt_ovf && !ext_rst) |=> (warm_rst && !full_rst && tof && pdf && !halted));

  // R7
  ext_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst |=> (full_rst && !pdf && !tof && !halted));

  // R9
  halted_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (halted && !ext_rst && !wdt_ovf && !irq && !port_fall) |=> (halted && !wdt_clr && $stable(pdf)));

  // R11
  reset_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(full_rst && warm_rst));

  // R11
  warm_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> !warm_rst);
endmodule

bind halt_rc_ctrl halt_rc_chk chk_i (
  .clk        (clk),
  .por_n      (por_n),
  .halt_cmd   (halt_cmd),
  .wdt_clr_cmd(wdt_clr_cmd),
  .ext_rst    (ext_rst),
  .irq        (irq),
  .wdt_ovf    (wdt_ovf),
  .port_fall  (port_fall),
  .halted     (halted),
  .full_rst   (full_rst),
  .warm_rst   (warm_rst),
  .wdt_clr    (wdt_clr),
  .pdf        (pdf),
  .tof        (tof)
);

// File: tb/halt_rc_ctrl_tb.sv
`timescale 1ns/1ps
module halt_rc_ctrl_tb_top;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          halt_cmd = 1'b0, wdt_clr_cmd = 1'b0, ext_rst = 1'b0, irq = 1'b0, wdt_ovf = 1'b0;
  logic [PW-1:0] port_in = '1;
  logic          clk_en, halted, full_rst, warm_rst, wdt_clr, pdf, tof;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  halt_rc_ctrl #(.PORT_W(PW)) dut_i (
    .clk(clk), .por_n(por_n), .halt_cmd(halt_cmd), .wdt_clr_cmd(wdt_clr_cmd),
    .ext_rst(ext_rst), .irq(irq), .port_in(port_in), .wdt_ovf(wdt_ovf),
    .clk_en(clk_en), .halted(halted), .full_rst(full_rst), .warm_rst(warm_rst),
    .wdt_clr(wdt_clr), .pdf(pdf), .tof(tof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Check all outputs at once, packed as {clk_en,halted,full,warm,clr,pdf,tof}
  task automatic chk_all(input string req, input string what, input logic [6:0] exp);
    chk(req, what, int'({clk_en, halted, full_rst, warm_rst, wdt_clr, pdf, tof}), int'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one cycle of requests: {halt, clr, ext, irq, ovf}
  task automatic req(input logic h, input logic c, input logic e, input logic i, input logic o);
    halt_cmd = h; wdt_clr_cmd = c; ext_rst = e; irq = i; wdt_ovf = o;
    @(negedge clk);
    halt_cmd = 0; wdt_clr_cmd = 0; ext_rst = 0; irq = 0; wdt_ovf = 0;
  endtask

  task automatic do_por();
    por_n = 1'b0; port_in = '1;
    idle(3);
    por_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    do_por();
    chk_all("R1", "state after power-up", 7'b1000000);
  endtask

  task automatic t_halt();
    do_por();
    req(1, 0, 0, 0, 0);
    chk_all("R2", "halt entry", 7'b0100110);
    idle(1);
    chk_all("R2", "wdt_clr one cycle", 7'b0100010);
  endtask

  task automatic t_irq_wake();
    do_por();
    req(1, 0, 0, 0, 0);
    req(0, 0, 0, 1, 0);
    chk_all("R3", "irq wake, no reset", 7'b1000010);
  endtask

  task automatic t_clear();
    do_por();
    req(0, 0, 0, 0, 1);            // tof = 1
    req(1, 0, 0, 0, 0);            // halt: pdf = 1, tof = 0
    req(0, 0, 0, 1, 0);            // wake
    req(0, 0, 0, 0, 1);            // tof = 1 again, pdf kept
    chk_all("R5", "run time-out keeps pdf", 7'b1010011);
    req(0, 1, 0, 0, 0);
    chk_all("R4", "clear cmd drops pdf keeps tof", 7'b1000101);
  endtask

  task automatic t_run_ovf();
    do_por();
    req(0, 0, 0, 0, 1);
    chk_all("R5", "run time-out full reset", 7'b1010001);
    idle(1);
    chk_all("R11", "full_rst one cycle", 7'b1000001);
  endtask

  task automatic t_halt_ovf();
    do_por();
    req(1, 0, 0, 0, 0);
    req(0, 0, 0, 0, 1);
    chk_all("R6", "halt time-out warm reset", 7'b1001011);
    idle(1);
    chk_all("R11", "warm_rst one cycle", 7'b1000011);
  endtask

  task automatic t_ext();
    do_por();
    req(0, 0, 0, 0, 1);
    req(1, 0, 0, 0, 0);
    req(0, 0, 1, 0, 0);
    chk_all("R7", "ext reset from halt", 7'b1010000);
    req(0, 0, 1, 0, 1);
    chk_all("R10", "ext beats time-out", 7'b1010000);
  endtask

  task automatic t_port();
    do_por();
    req(1, 0, 0, 0, 0);
    port_in[3] = 1'b0;
    idle(2);
    chk("R8", "still halted two edges after fall", int'(halted), 1);
    idle(1);
    chk_all("R8", "port fall wake", 7'b1000010);
    // fall while running must not wake a later halt; rising must not wake
    port_in = '1;
    idle(4);
    port_in[5] = 1'b0;
    idle(4);
    req(1, 0, 0, 0, 0);
    idle(4);
    chk("R8", "stale fall does not wake", int'(halted), 1);
    port_in = '1;
    idle(4);
    chk("R8", "rising edge does not wake", int'(halted), 1);
  endtask

  task automatic t_ignored();
    do_por();
    req(1, 0, 0, 0, 0);
    idle(1);
    req(0, 1, 0, 0, 0);
    chk_all("R9", "clear cmd while halted", 7'b0100010);
    req(1, 0, 0, 0, 0);
    chk_all("R9", "halt cmd while halted", 7'b0100010);
  endtask

  task automatic t_collide();
    do_por();
    req(1, 0, 0, 0, 1);
    chk_all("R10", "time-out beats halt", 7'b1010001);
    idle(1);
    req(1, 1, 0, 0, 0);
    chk_all("R10", "halt beats clear", 7'b0100110);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_halt();
    t_irq_wake();
    t_clear();
    t_run_ovf();
    t_halt_ovf();
    t_ext();
    t_port();
    t_ignored();
    t_collide();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end
endmodule